// File: doc/BRIEF.md
# Early/Late Phase Detector

This block is the digital decision core of a bang-bang clock recovery loop. It samples a non-return-to-zero serial stream with one clock running at twice the bit rate. An internal phase bit alternates between a bit-centre slot and an edge slot, which stands in for the two edges of an oscillator clock. Each decision looks at three samples: the earlier centre, the edge sample between the two centres, and the later centre. From these it gives one registered decision per bit period: advance the clock (up), retard it (down) or leave it alone (hold). A decision is only made when the two centre samples differ.

Next to the decision, the block outputs the retimed data bit. This is the centre sample, delayed by one bit. A loop that has locked puts the edge slot on the data transitions, so the centre slots fall in the middle of the eye. The decision is built from two intermediate difference nodes that have equal loading. An alternative form, chosen by parameter, gives the same truth table.

Top module: `elpd_top`

## Requirements
- R1: The first rising edge with reset low takes a centre sample. Sampling then alternates edge, centre, edge and so on. Numbering rising edges after reset as k = 1, 2, 3 and so on, each odd edge k takes a centre sample and each even edge takes an edge sample.
- R2: If the earlier centre, the edge sample and the later centre are all equal, both upPulse and downPulse are 0.
- R3: downPulse is 1 (clock early) when the two centre samples differ and the edge sample equals the earlier centre.
- R4: upPulse is 1 (clock late) when the two centre samples differ and the edge sample equals the later centre.
- R5: upPulse and downPulse are never 1 in the same cycle.
- R6: The outputs change only at even edges and hold their value for two clock cycles (one bit period). The outputs after even edge k (k of 4 or more) decide on the sample triple taken at edges k-3 (earlier centre), k-2 (edge) and k-1 (later centre).
- R7: retimedBit, updated with each decision, equals the earlier centre sample of that decision's triple.
- R8: A synchronous reset clears every sample and output register. Until two centre samples exist, the outputs stay 0: after edges 1 to 3 all outputs read 0.
- R9: The equally loaded form (SYMMETRIC=1, the default) gives the same up/down truth table as the direct form.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bit rate |
| rst | input | 1 | Synchronous reset, active high |
| serialIn | input | 1 | Serial NRZ data |
| upPulse | output | 1 | Clock late: advance the oscillator |
| downPulse | output | 1 | Clock early: retard the oscillator |
| retimedBit | output | 1 | Recovered bit, one bit behind |

## Verification
A phase bit that is off by one would swap the centre and edge roles. The up and down outputs would then disagree with the expected decision at the first even edge after a transition, and would move on odd edges. An edge sample that is not moved onto the centre phase pairs the wrong edge with its centres. A transition at the edge slot then shows as a wrong up or down within one bit period. A wrong start-up count shows up as spurious pulses at edge 2, or as a missing decision at edge 4.

// File: rtl/elpd_pkg.sv
package elpd_pkg;

  typedef enum logic {
    PH_CENTER = 1'b0,
    PH_EDGE   = 1'b1
  } elpd_phase_t;

  typedef struct packed {
    logic takeCenter;
    logic takeEdge;
    logic armed;
  } elpd_strobe_t;

endpackage

// File: rtl/elpd_ctrl.sv
module elpd_ctrl
  import elpd_pkg::*;
#(
  parameter int FILL_CENTERS = 2
) (
  input  logic         clk,
  input  logic         rst,
  output elpd_strobe_t strobe
);

  localparam int FILL_W = $clog2(FILL_CENTERS + 1);
  localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(FILL_CENTERS);

  elpd_phase_t       phase;
  logic [FILL_W-1:0] fillCount;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_CENTER;
      fillCount <= '0;
    end else begin
      phase <= (phase == PH_CENTER) ? PH_EDGE : PH_CENTER;
      if (phase == PH_CENTER && fillCount != FILL_MAX)
        fillCount <= fillCount + 1'b1;
    end
  end

  always_comb begin
    strobe.takeCenter = (phase == PH_CENTER);
    strobe.takeEdge   = (phase == PH_EDGE);
    strobe.armed      = (fillCount == FILL_MAX);
  end

  // R1: the phase alternates every clock once reset is released
  p_phase_alternates_r1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> phase != $past(phase));

  // R8: arming never drops without a reset
  p_armed_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    strobe.armed |=> strobe.armed);

endmodule

// File: rtl/elpd_path.sv
module elpd_path
  import elpd_pkg::*;
#(
  parameter bit SYMMETRIC = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  elpd_strobe_t strobe,
  input  logic         serialIn,
  output logic         upPulse,
  output logic         downPulse,
  output logic         retimedBit
);

  logic edgeRaw;
  logic earlyCtr;
  logic edgeAligned;
  logic lateCtr;
  logic upNext;
  logic downNext;

  always_ff @(posedge clk) begin
    if (rst) begin
      edgeRaw     <= 1'b0;
      earlyCtr    <= 1'b0;
      edgeAligned <= 1'b0;
      lateCtr     <= 1'b0;
    end else begin
      if (strobe.takeCenter) begin
        lateCtr     <= serialIn;
        earlyCtr    <= lateCtr;
        edgeAligned <= edgeRaw;
      end
      if (strobe.takeEdge)
        edgeRaw <= serialIn;
    end
  end

  generate
    if (SYMMETRIC) begin : g_sym
      logic xNode;
      logic yNode;
      assign xNode    = earlyCtr ^ edgeAligned;
      assign yNode    = edgeAligned ^ lateCtr;
      assign upNext   = xNode & ~yNode;
      assign downNext = ~xNode & yNode;
    end else begin : g_direct
      logic xNode;
      logic yNode;
      assign xNode    = earlyCtr ^ lateCtr;
      assign yNode    = earlyCtr ^ edgeAligned;
      assign upNext   = xNode & yNode;
      assign downNext = xNode & ~yNode;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      upPulse    <= 1'b0;
      downPulse  <= 1'b0;
      retimedBit <= 1'b0;
    end else if (strobe.takeEdge) begin
      if (strobe.armed) begin
        upPulse    <= upNext;
        downPulse  <= downNext;
        retimedBit <= earlyCtr;
      end else begin
        upPulse    <= 1'b0;
        downPulse  <= 1'b0;
        retimedBit <= 1'b0;
      end
    end
  end

  p_exclusive_r5: assert property (@(posedge clk) disable iff (rst)
    !(upPulse && downPulse));

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    strobe.takeEdge && strobe.armed && earlyCtr == edgeAligned && edgeAligned == lateCtr
    |=> !upPulse && !downPulse);

  p_down_r3: assert property (@(posedge clk) disable iff (rst)
    strobe.takeEdge && strobe.armed && earlyCtr != lateCtr && edgeAligned == earlyCtr
    |=> downPulse && !upPulse);

  p_up_r4: assert property (@(posedge clk) disable iff (rst)
    strobe.takeEdge && strobe.armed && earlyCtr != lateCtr && edgeAligned != earlyCtr
    |=> upPulse && !downPulse);

  p_stable_r6: assert property (@(posedge clk) disable iff (rst)
    strobe.takeCenter |=> $stable(upPulse) && $stable(downPulse) && $stable(retimedBit));

  p_retimed_r7: assert property (@(posedge clk) disable iff (rst)
    strobe.takeEdge && strobe.armed |=> retimedBit == $past(earlyCtr));

endmodule

// File: rtl/elpd_top.sv
module elpd_top
  import elpd_pkg::*;
#(
  parameter bit SYMMETRIC    = 1'b1,
  parameter int FILL_CENTERS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic serialIn,
  output logic upPulse,
  output logic downPulse,
  output logic retimedBit
);

  elpd_strobe_t strobe;

  elpd_ctrl #(
    .FILL_CENTERS(FILL_CENTERS)
  ) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .strobe(strobe)
  );

  elpd_path #(
    .SYMMETRIC(SYMMETRIC)
  ) u_path (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .serialIn  (serialIn),
    .upPulse   (upPulse),
    .downPulse (downPulse),
    .retimedBit(retimedBit)
  );

endmodule

// File: tb/elpd_top_bench.sv
`timescale 1ns/1ps
module elpd_top_bench;

  logic clk = 1'b0;
  logic rst;
  logic serialIn;
  logic upPulse;
  logic downPulse;
  logic retimedBit;

  int   checks = 0;
  int   fails  = 0;
  int   k      = 0;
  bit   done   = 1'b0;
  logic hist [0:4095];
  logic expUp, expDown, expRet;

  always #5 clk = ~clk;

  elpd_top u_elpd_top (
    .clk       (clk),
    .rst       (rst),
    .serialIn  (serialIn),
    .upPulse   (upPulse),
    .downPulse (downPulse),
    .retimedBit(retimedBit)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at k=%0d: actual %b expected %b", tag, k, act, exp);
    end
  endtask

  function automatic logic predUp(input logic a, input logic e, input logic b);
    return (a != b) && (e == b);
  endfunction

  function automatic logic predDown(input logic a, input logic e, input logic b);
    return (a != b) && (e == a);
  endfunction

  // R1, R6, R8: expected outputs follow from the edge number k alone
  task automatic stepCycle(input logic v);
    string tag;
    serialIn = v;
    k++;
    hist[k] = v;
    @(posedge clk);
    @(negedge clk);
    if (k % 2 == 0) begin
      if (k >= 4) begin
        expUp   = predUp(hist[k-3], hist[k-2], hist[k-1]);
        expDown = predDown(hist[k-3], hist[k-2], hist[k-1]);
        expRet  = hist[k-3];
        if (expUp)        tag = "R4 up (R1 R9)";
        else if (expDown) tag = "R3 down (R1 R9)";
        else              tag = "R2 hold";
      end else begin
        expUp = 1'b0; expDown = 1'b0; expRet = 1'b0;
        tag = "R8 startup";
      end
    end else begin
      tag = (k < 4) ? "R8 startup" : "R6 held";
    end
    chk({tag, " upPulse"},   upPulse,   expUp);
    chk({tag, " downPulse"}, downPulse, expDown);
    chk("R7 retimedBit",     retimedBit, expRet);
    chk("R5 exclusive",      upPulse & downPulse, 1'b0);
  endtask

  task automatic doReset();
    rst = 1'b1;
    serialIn = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    chk("R8 reset upPulse",    upPulse,    1'b0);
    chk("R8 reset downPulse",  downPulse,  1'b0);
    chk("R8 reset retimedBit", retimedBit, 1'b0);
    rst = 1'b0;
    k = 0;
    expUp = 1'b0; expDown = 1'b0; expRet = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    rst = 1'b1;
    serialIn = 1'b0;
    void'($urandom(32'd20240611));
    @(negedge clk);
    doReset();
    // R2: a steady level gives only holds
    for (int i = 0; i < 20; i++) stepCycle(1'b0);
    for (int i = 0; i < 20; i++) stepCycle(1'b1);
    // R3: the edge slot repeats the earlier centre, so the clock is early
    for (int i = 0; i < 40; i++) stepCycle((i % 4) >= 2);
    // R4: the edge slot already holds the new bit, so the clock is late
    for (int i = 0; i < 40; i++) stepCycle(((i + 1) % 4) >= 2);
    // R8: reset in the middle of traffic, then start-up suppression again
    doReset();
    for (int i = 0; i < 8; i++) stepCycle(i[0]);
    // R9: all eight triples (earlier centre, edge, later centre)
    for (int t = 0; t < 8; t++) begin
      stepCycle(t[2]);
      stepCycle(t[1]);
      stepCycle(t[0]);
      stepCycle(t[0]);
    end
    // random traffic
    doReset();
    for (int i = 0; i < 3000; i++) stepCycle(1'($urandom()));
    finishRun();
  end

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

endmodule